// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Selector

This block holds the digital divider path of a clock synthesizer, modelled in a fast simulation clock domain. Rates are carried as single-cycle enables. `vco_tick` marks each half-period of the VCO-rate waveform, so a divide-by-1 output toggles on every tick. `ref_tick` marks each reference edge that is to be counted. `sclk` is a level that the block samples, and its rising edges are counted. The analog phase detector and the VCO are not part of this block.

A reference divider produces the reference divided by 16. A feedback divider divides VCO ticks by M and then toggles a flip-flop, which gives a further divide by 2. A post-divider produces the output clock at 50% duty cycle with a ratio of 1, 2, 4 or 8. A 3-bit test code chooses which internal signal drives the test output. One test code also switches the post-divider's input from VCO ticks to serial-clock edges. New M and N values take effect only at divider boundaries, so a reprogramming step never produces a runt pulse.

Top module: `synth_div_chain`

## Requirements
- R1: With test code 010 the test output is the reference divided by 16: it stays high for 8 reference ticks and low for 8.
- R2: The output clock `fout` stays high for L VCO ticks and low for L VCO ticks. L depends on `n_code`: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 1. `fout` is registered one clock after the post-divider.
- R3: While `out_en` is low, `fout` is held low from the next clock on, and the test output keeps running.
- R4: Test code 000 drives the test output from `shift_bit`. Code 001 drives it high and code 101 drives it low.
- R5: With test code 011 the test output toggles once every M VCO ticks. Its high and low phases each last M ticks.
- R6: With test code 100 the test output carries the post-divider clock, with the half-period L of R2.
- R7: With test code 110 the post-divider counts rising edges of `sclk` in place of VCO ticks. The test output then toggles once every M `sclk` rising edges.
- R8: With test code 111 the test output is the post-divider clock divided by 4, with a period of 8·L source ticks.
- R9: A change of `n_code` takes effect only when the post-divider output rises. A phase already under way, and the low phase after it, keep the old length.
- R10: A change of `m_val` takes effect only at the M divider's terminal count. The half-phase already under way keeps the old length.
- R11: While `rst_n` is low, `fout` is low and the reference-divided test output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One-cycle pulse per VCO half-period |
| ref_tick | input | 1 | One-cycle pulse per counted reference edge |
| sclk | input | 1 | Serial clock level, sampled on clk |
| shift_bit | input | 1 | Serial shift-register output bit |
| m_val | input | 9 | Feedback divide ratio M |
| n_code | input | 2 | Post-divider select code |
| test_code | input | 3 | Test output select code |
| out_en | input | 1 | Output enable for fout |
| fout | output | 1 | Output clock |
| test_out | output | 1 | Test output |

## Verification
The assertions assume the following about the inputs:
- `sclk` is synchronous to `clk` and stays at each level for at least one clock.
- The tick enables are plain single-cycle qualifiers.
- `m_val` is nonzero while it is in use.

Under these assumptions every toggle of a divider output follows a counted tick, and ratios load only at boundaries. The stimulus keeps to these limits: it drives every input on the falling clock edge, toggles `sclk` once per clock, and uses M values of 2 or more. It measures the high and low widths of `fout` and `test_out` in clock cycles, and changes M and N in the middle of a phase to expose a runt.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int M_W      = 9;
  localparam int N_W      = 2;
  localparam int T_W      = 3;
  localparam int REF_DIV  = 16;

  typedef enum logic [T_W-1:0] {
    TST_SHIFT = 3'b000,
    TST_HIGH  = 3'b001,
    TST_REF   = 3'b010,
    TST_MVCO  = 3'b011,
    TST_FOUT  = 3'b100,
    TST_LOW   = 3'b101,
    TST_SCLK  = 3'b110,
    TST_FOUT4 = 3'b111
  } test_sel_e;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic div_out
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          out_q, out_nxt;
  logic          tc;

  assign tc = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_nxt = cnt_q;
    out_nxt = out_q;
    if (tick) begin
      if (tc) begin
        cnt_nxt = '0;
        out_nxt = ~out_q;
      end else begin
        cnt_nxt = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      out_q <= out_nxt;
    end
  end

  assign div_out = out_q;

  AST_REF_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(tick)); // R1
endmodule

// File: rtl/m_divider.sv
module m_divider #(
  parameter int MW    = 9,
  parameter int M_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [MW-1:0] m_req,
  output logic          div_out
);
  logic [MW-1:0] cnt_q, cnt_nxt;
  logic [MW-1:0] m_act_q, m_act_nxt;
  logic          out_q, out_nxt;
  logic          tc;

  assign tc = (({1'b0, cnt_q} + (MW+1)'(1)) >= {1'b0, m_act_q});

  always_comb begin
    cnt_nxt   = cnt_q;
    m_act_nxt = m_act_q;
    out_nxt   = out_q;
    if (tick) begin
      if (tc) begin
        cnt_nxt   = '0;
        out_nxt   = ~out_q;
        m_act_nxt = m_req;
      end else begin
        cnt_nxt = cnt_q + MW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      m_act_q <= MW'(M_RST);
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      m_act_q <= m_act_nxt;
      out_q   <= out_nxt;
    end
  end

  assign div_out = out_q;

  AST_M_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_act_q) |-> !$stable(out_q)); // R10
  AST_M_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(tick)); // R5
endmodule

// File: rtl/post_divider.sv
module post_divider #(
  parameter int NW    = 2,
  parameter int N_RST = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NW-1:0] n_req,
  output logic          clk_out,
  output logic          clk_div4
);
  localparam int HW = 4;

  logic [NW-1:0] n_act_q, n_act_nxt;
  logic [HW-1:0] hcnt_q, hcnt_nxt;
  logic [HW-1:0] half_len;
  logic          out_q, out_nxt;
  logic [1:0]    q4_q, q4_nxt;
  logic          tc;

  always_comb begin
    case (n_act_q)
      2'b00:   half_len = HW'(2);
      2'b01:   half_len = HW'(4);
      2'b10:   half_len = HW'(8);
      default: half_len = HW'(1);
    endcase
  end

  assign tc = (hcnt_q == (half_len - HW'(1)));

  always_comb begin
    hcnt_nxt  = hcnt_q;
    out_nxt   = out_q;
    n_act_nxt = n_act_q;
    q4_nxt    = q4_q;
    if (tick) begin
      if (tc) begin
        hcnt_nxt = '0;
        out_nxt  = ~out_q;
        if (!out_q) begin
          n_act_nxt = n_req;
          q4_nxt    = q4_q + 2'd1;
        end
      end else begin
        hcnt_nxt = hcnt_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      out_q   <= 1'b0;
      n_act_q <= NW'(N_RST);
      q4_q    <= '0;
    end else begin
      hcnt_q  <= hcnt_nxt;
      out_q   <= out_nxt;
      n_act_q <= n_act_nxt;
      q4_q    <= q4_nxt;
    end
  end

  assign clk_out  = out_q;
  assign clk_div4 = q4_q[1];

  AST_N_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_act_q) |-> $rose(out_q)); // R9
  AST_POST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(tick)); // R2
  AST_DIV4_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q4_q) |-> $rose(out_q)); // R8
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int M_RST = 4,
  parameter int N_RST = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_tick,
  input  logic           ref_tick,
  input  logic           sclk,
  input  logic           shift_bit,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_code,
  input  logic [T_W-1:0] test_code,
  input  logic           out_en,
  output logic           fout,
  output logic           test_out
);
  test_sel_e sel;
  logic      sclk_q;
  logic      sclk_rise;
  logic      post_tick;
  logic      ref_div_out;
  logic      mvco_out;
  logic      msclk_out;
  logic      post_out;
  logic      post_div4;
  logic      fout_q, fout_nxt;

  assign sel       = test_sel_e'(test_code);
  assign sclk_rise = sclk & ~sclk_q;
  assign post_tick = (sel == TST_SCLK) ? sclk_rise : vco_tick;

  ref_divider #(.DIV(REF_DIV)) u_ref_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ref_tick),
    .div_out (ref_div_out)
  );

  m_divider #(.MW(M_W), .M_RST(M_RST)) u_m_vco (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (vco_tick),
    .m_req   (m_val),
    .div_out (mvco_out)
  );

  m_divider #(.MW(M_W), .M_RST(M_RST)) u_m_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sclk_rise),
    .m_req   (m_val),
    .div_out (msclk_out)
  );

  post_divider #(.NW(N_W), .N_RST(N_RST)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (post_tick),
    .n_req    (n_code),
    .clk_out  (post_out),
    .clk_div4 (post_div4)
  );

  assign fout_nxt = out_en & post_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      fout_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      fout_q <= fout_nxt;
    end
  end

  always_comb begin
    case (sel)
      TST_SHIFT: test_out = shift_bit;
      TST_HIGH:  test_out = 1'b1;
      TST_REF:   test_out = ref_div_out;
      TST_MVCO:  test_out = mvco_out;
      TST_FOUT:  test_out = post_out;
      TST_LOW:   test_out = 1'b0;
      TST_SCLK:  test_out = msclk_out;
      default:   test_out = post_div4;
    endcase
  end

  assign fout = fout_q;

  AST_OE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_en) |-> !fout); // R3
  AST_SCLK_FEEDS_POST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel == TST_SCLK) && !$stable(post_out)) |-> $past(sclk_rise)); // R7
endmodule

// File: tb/synth_div_chain_tb.sv
`timescale 1ns/1ps
module synth_div_chain_tb;
  localparam real HALF_NS = 2.0;

  typedef struct packed {
    logic [2:0] t;
    logic [1:0] n;
    logic [8:0] m;
    logic       on_test;
    logic [7:0] hi;
    logic [7:0] per;
    logic [3:0] req;
  } vec_t;

  // on_test: 0 measures fout, 1 measures test_out
  localparam vec_t VEC [12] = '{
    '{3'b100, 2'b00, 9'd4, 1'b0, 8'd2,  8'd4,  4'd2},  // R2 code 00
    '{3'b100, 2'b01, 9'd4, 1'b0, 8'd4,  8'd8,  4'd2},  // R2 code 01
    '{3'b100, 2'b10, 9'd4, 1'b0, 8'd8,  8'd16, 4'd2},  // R2 code 10
    '{3'b100, 2'b11, 9'd4, 1'b0, 8'd1,  8'd2,  4'd2},  // R2 code 11
    '{3'b011, 2'b00, 9'd5, 1'b1, 8'd5,  8'd10, 4'd5},  // R5
    '{3'b011, 2'b00, 9'd2, 1'b1, 8'd2,  8'd4,  4'd5},  // R5
    '{3'b010, 2'b00, 9'd4, 1'b1, 8'd8,  8'd16, 4'd1},  // R1
    '{3'b100, 2'b01, 9'd4, 1'b1, 8'd4,  8'd8,  4'd6},  // R6
    '{3'b111, 2'b00, 9'd4, 1'b1, 8'd8,  8'd16, 4'd8},  // R8
    '{3'b111, 2'b11, 9'd4, 1'b1, 8'd4,  8'd8,  4'd8},  // R8
    '{3'b110, 2'b00, 9'd4, 1'b0, 8'd4,  8'd8,  4'd7},  // R7 fout from sclk
    '{3'b110, 2'b00, 9'd3, 1'b1, 8'd6,  8'd12, 4'd7}   // R7 test from sclk
  };

  logic       clk, rst_n, vco_tick, ref_tick, sclk, shift_bit, out_en;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] test_code;
  logic       fout, test_out;
  int         n_tests, n_fail;
  bit         done;

  synth_div_chain u_dut (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .sclk(sclk), .shift_bit(shift_bit), .m_val(m_val), .n_code(n_code),
    .test_code(test_code), .out_en(out_en), .fout(fout), .test_out(test_out)
  );

  initial begin
    clk = 1'b0;
    forever #(HALF_NS) clk = ~clk;
  end

  initial begin
    sclk = 1'b0;
    forever begin
      @(negedge clk);
      sclk = ~sclk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input logic on_test);
    return on_test ? test_out : fout;
  endfunction

  task automatic wait_rise(input logic on_test);
    int guard = 0;
    @(negedge clk);
    while (pick(on_test) !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    while (pick(on_test) !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
  endtask

  task automatic measure(input logic on_test, output int hi, output int lo);
    wait_rise(on_test);
    hi = 0;
    lo = 0;
    while (pick(on_test) === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
    while (pick(on_test) === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(HALF_NS * 2 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi, lo;
    n_tests = 0;
    n_fail = 0;
    rst_n = 1'b0;
    vco_tick = 1'b1;
    ref_tick = 1'b1;
    shift_bit = 1'b0;
    out_en = 1'b1;
    m_val = 9'd4;
    n_code = 2'b00;
    test_code = 3'b010;
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 fout in reset", int'(fout), 0);
    check("R11 ref test in reset", int'(test_out), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      test_code = VEC[i].t;
      n_code = VEC[i].n;
      m_val = VEC[i].m;
      repeat (80) @(negedge clk);
      measure(VEC[i].on_test, hi, lo);
      n_tests++;
      if (hi != int'(VEC[i].hi) || (hi + lo) != int'(VEC[i].per)) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual hi=%0d per=%0d expected hi=%0d per=%0d",
                 VEC[i].req, i, hi, hi + lo, VEC[i].hi, VEC[i].per);
      end
    end

    // R4: static test codes
    test_code = 3'b000; shift_bit = 1'b1;
    @(negedge clk); check("R4 code000 bit1", int'(test_out), 1);
    shift_bit = 1'b0;
    @(negedge clk); check("R4 code000 bit0", int'(test_out), 0);
    test_code = 3'b001;
    @(negedge clk); check("R4 code001", int'(test_out), 1);
    test_code = 3'b101;
    @(negedge clk); check("R4 code101", int'(test_out), 0);

    // R3: output enable low holds fout, test output keeps toggling
    test_code = 3'b100; n_code = 2'b00;
    out_en = 1'b0;
    repeat (3) @(negedge clk);
    begin
      int fhigh = 0;
      int tedges = 0;
      logic prev = test_out;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (fout) fhigh++;
        if (test_out != prev) tedges++;
        prev = test_out;
      end
      check("R3 fout high cycles with oe low", fhigh, 0);
      check("R3 test output still toggles", int'(tedges > 0), 1);
    end
    out_en = 1'b1;

    // R9: N change mid high phase waits for next rising edge
    test_code = 3'b100; n_code = 2'b10;
    repeat (80) @(negedge clk);
    wait_rise(1'b0);
    hi = 0;
    lo = 0;
    while (fout === 1'b1 && hi < 500) begin
      hi++;
      if (hi == 3) n_code = 2'b11;
      @(negedge clk);
    end
    while (fout === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
    check("R9 high width keeps old N", hi, 8);
    check("R9 low width keeps old N", lo, 8);
    hi = 0;
    while (fout === 1'b1 && hi < 500) begin hi++; @(negedge clk); end
    check("R9 next high uses new N", hi, 1);

    // R10: M change mid phase applies at terminal count
    test_code = 3'b011; m_val = 9'd5;
    repeat (80) @(negedge clk);
    wait_rise(1'b1);
    hi = 0;
    lo = 0;
    while (test_out === 1'b1 && hi < 500) begin
      hi++;
      if (hi == 2) m_val = 9'd3;
      @(negedge clk);
    end
    while (test_out === 1'b0 && lo < 500) begin lo++; @(negedge clk); end
    check("R10 current half keeps old M", hi, 5);
    check("R10 next half uses new M", lo, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule